// File: doc/BRIEF.md
# Per-Channel Underrun and Cut-Connection Detector

Each voice channel in this block plays out bytes from a buffer that a packet network fills. Once per frame, the channel being served reports one of two outcomes: a good byte reached the output, or the buffer was empty (an underrun). The block keeps one control word per channel. The word holds an 8-bit underrun tally and two mode bits. From these outcomes it maintains a global underrun counter, a sticky underrun flag and a cut-connection record. The cut-connection record has a counter, the id of the last channel cut, and a level interrupt.

The tally works in one of two modes:

- **Running total:** it counts every underrun and wraps past 255.
- **Cut detection:** it counts only consecutive underruns, clears on every good byte, and stops at 255. Only the step from 254 to 255 raises a cut. At one byte per 125 µs frame, 255 consecutive empty frames is roughly 32 ms of silence.

Software preloads the tally before it enables a channel: 255 for cut detection, 0 for the running total. Software can also poll a cut channel's tally to see it fall back to 0 when data returns.

Top module: `chan_underrun_monitor`

## Requirements
- R1: After reset every channel word reads 0, both global counters read 0, the status register reads 0 and `cut_irq` is low.
- R2: An underrun on a channel whose report bit (word bit 8) is 1 adds one to the global underrun counter and sets status bit 0. Both take effect on the clock edge that accepts the event. If the report bit is 0, neither changes.
- R3: With the cut-mode bit (word bit 9) at 0, each underrun adds one to the tally (word bits 7:0) modulo 256, so 0xFF becomes 0x00. A good byte leaves the tally unchanged.
- R4: With the cut-mode bit at 1, a good byte clears the tally to 0. An underrun adds one, but a tally of 0xFF stays at 0xFF.
- R5: In cut mode, an underrun that moves the tally from 0xFE to 0xFF has four effects: it adds one to the cut counter, loads the channel number into the cut-id register, sets status bit 1, and drives `cut_irq` high.
- R6: In cut mode, an underrun on a tally already at 0xFF does not change the cut counter, the cut id or `cut_irq`. This also applies to a tally preloaded to 0xFF.
- R7: The status bits are sticky. Writing 1 to a status bit clears it, and writing 0 has no effect. `cut_irq` follows status bit 1. A second cut while bit 1 is set still adds one to the cut counter and replaces the cut id.
- R8: If a software write and an event reach the same channel word in the same cycle, the event's update is applied to the newly written value. If they reach different channels, both take effect.
- R9: Both global counters are 16 bits wide and stop at 0xFFFF. Any write to a counter clears it. If an increment arrives in the same cycle as the clearing write, the counter reads 1.
- R10: Register map (address bit 5 clear selects a channel): address n in 0..31 is channel n's word. Address 32 is status, 33 the underrun counter, 34 the cut counter and 35 the cut id. Reads return the current value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A frame outcome is presented this cycle |
| ev_chan | input | 5 | Channel the outcome belongs to |
| ev_underrun | input | 1 | 1 = underrun, 0 = good byte |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| cut_irq | output | 1 | Cut interrupt, held until cleared |

## Verification
The tally is driven with several patterns:

- **Wrap runs:** runs of underruns across the 0xFF boundary in running-total mode separate wrapping from saturation.
- **Interleaved good bytes:** good bytes placed between underruns separate the two modes' clearing rules.
- **Cut-mode preloads:** preloads of 0xFD, 0xFE and 0xFF show that only the single 0xFE-to-0xFF step raises a cut.
- **Report bit off:** underruns on a channel with its report bit cleared show that the global counter ignores that channel.
- **Collisions:** a write landing in the same cycle as an event, on the same channel and on a different one, shows the ordering between the two writers.
- **Long run:** one long unbroken run of underruns drives the global counter into saturation.

// File: rtl/urm_pkg.sv
package urm_pkg;

    // Per-channel control word: {cut_mode, rpt_en, ur_count}
    typedef struct packed {
        logic       cut_mode;
        logic       rpt_en;
        logic [7:0] ur_count;
    } chan_word_t;

    localparam int WORD_W = $bits(chan_word_t);
    localparam int REG_W  = 16;

    localparam logic [1:0] GREG_STATUS = 2'd0;
    localparam logic [1:0] GREG_URCNT  = 2'd1;
    localparam logic [1:0] GREG_CUTCNT = 2'd2;
    localparam logic [1:0] GREG_CUTID  = 2'd3;

endpackage

// File: rtl/urm_chan_update.sv
module urm_chan_update
    import urm_pkg::*;
(
    input  chan_word_t word_in,
    input  logic       hit,
    input  logic       is_underrun,
    output chan_word_t word_out,
    output logic       report_ur,
    output logic       cut_hit
);

    always_comb begin
        word_out  = word_in;
        report_ur = 1'b0;
        cut_hit   = 1'b0;
        if (hit) begin
            if (is_underrun) begin
                report_ur = word_in.rpt_en;
                if (word_in.cut_mode) begin
                    if (word_in.ur_count != 8'hFF) begin
                        word_out.ur_count = word_in.ur_count + 8'd1;
                    end
                    cut_hit = (word_in.ur_count == 8'hFE);
                end else begin
                    word_out.ur_count = word_in.ur_count + 8'd1;
                end
            end else if (word_in.cut_mode) begin
                word_out.ur_count = 8'h00;
            end
        end
    end

endmodule

// File: rtl/urm_sat_cnt.sv
module urm_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = clr ? '0 : q_q;
        if (inc && (q_d != '1)) begin
            q_d = q_d + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

    // R9: a full counter stays full unless cleared
    a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (q_q == '1 && !clr) |=> (q_q == '1));

    // R9: a clear with no increment leaves zero
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !inc) |=> (q_q == '0));

endmodule

// File: rtl/chan_underrun_monitor.sv
module chan_underrun_monitor
    import urm_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CH_W-1:0]   ev_chan,
    input  logic              ev_underrun,
    input  logic              reg_we,
    input  logic [CH_W:0]     reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              cut_irq
);

    localparam int NUM_CH = 1 << CH_W;

    typedef struct packed {
        chan_word_t [NUM_CH-1:0] words;
        logic [CH_W-1:0]         cut_id;
        logic                    ur_seen;
        logic                    cut_pend;
    } state_t;

    state_t st_d, st_q;

    logic            sw_chan_wr, sw_glob_wr;
    logic [CH_W-1:0] sw_chan;
    logic [1:0]      gsel;
    chan_word_t      base_word, new_word;
    logic            report_ur, cut_hit;
    logic [CNT_W-1:0] ur_cnt_q, cut_cnt_q;

    assign sw_chan_wr = reg_we && !reg_addr[CH_W];
    assign sw_glob_wr = reg_we &&  reg_addr[CH_W];
    assign sw_chan    = reg_addr[CH_W-1:0];
    assign gsel       = reg_addr[1:0];

    // Same-channel collision: the event acts on the freshly written word
    assign base_word = (sw_chan_wr && (sw_chan == ev_chan))
                     ? chan_word_t'(reg_wdata[WORD_W-1:0])
                     : st_q.words[ev_chan];

    urm_chan_update u_update (
        .word_in     (base_word),
        .hit         (ev_valid),
        .is_underrun (ev_underrun),
        .word_out    (new_word),
        .report_ur   (report_ur),
        .cut_hit     (cut_hit)
    );

    urm_sat_cnt #(.W(CNT_W)) u_ur_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_glob_wr && gsel == GREG_URCNT),
        .inc   (report_ur),
        .q     (ur_cnt_q)
    );

    urm_sat_cnt #(.W(CNT_W)) u_cut_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sw_glob_wr && gsel == GREG_CUTCNT),
        .inc   (cut_hit),
        .q     (cut_cnt_q)
    );

    always_comb begin
        st_d = st_q;
        if (sw_chan_wr) begin
            st_d.words[sw_chan] = chan_word_t'(reg_wdata[WORD_W-1:0]);
        end
        if (ev_valid) begin
            st_d.words[ev_chan] = new_word;
        end
        if (sw_glob_wr && gsel == GREG_STATUS) begin
            if (reg_wdata[0]) st_d.ur_seen  = 1'b0;
            if (reg_wdata[1]) st_d.cut_pend = 1'b0;
        end
        if (report_ur) st_d.ur_seen = 1'b1;
        if (cut_hit) begin
            st_d.cut_pend = 1'b1;
            st_d.cut_id   = ev_chan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr[CH_W]) begin
            reg_rdata = REG_W'(st_q.words[sw_chan]);
        end else begin
            unique case (gsel)
                GREG_STATUS: reg_rdata = REG_W'({st_q.cut_pend, st_q.ur_seen});
                GREG_URCNT:  reg_rdata = REG_W'(ur_cnt_q);
                GREG_CUTCNT: reg_rdata = REG_W'(cut_cnt_q);
                default:     reg_rdata = REG_W'(st_q.cut_id);
            endcase
        end
    end

    assign cut_irq = st_q.cut_pend;

    // R5: the 0xFE-to-0xFF step raises the interrupt
    a_r5_cut_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_underrun && !reg_we && st_q.words[ev_chan].cut_mode
         && st_q.words[ev_chan].ur_count == 8'hFE) |=> cut_irq);

    // R4: a good byte in cut mode empties the tally
    a_r4_good_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_underrun && !reg_we && st_q.words[ev_chan].cut_mode)
        |=> (st_q.words[$past(ev_chan)].ur_count == 8'h00));

    // R6: a saturated tally raises no further cut
    a_r6_no_repeat_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_underrun && !reg_we && st_q.words[ev_chan].cut_mode
         && st_q.words[ev_chan].ur_count == 8'hFF) |=> $stable(cut_cnt_q));

    // R2: a channel with reporting off leaves the global counter alone
    a_r2_gate_report: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_underrun && !reg_we && !st_q.words[ev_chan].rpt_en)
        |=> $stable(ur_cnt_q));

    // R7: the interrupt holds until software clears it
    a_r7_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_irq && !(sw_glob_wr && gsel == GREG_STATUS && reg_wdata[1]))
        |=> cut_irq);

endmodule

// File: tb/chan_underrun_monitor_bench.sv
module chan_underrun_monitor_bench;

    localparam int AW = 6;
    localparam logic [AW-1:0] A_STAT   = 6'd32;
    localparam logic [AW-1:0] A_URCNT  = 6'd33;
    localparam logic [AW-1:0] A_CUTCNT = 6'd34;
    localparam logic [AW-1:0] A_CUTID  = 6'd35;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [4:0]  ev_chan = '0;
    logic        ev_underrun = 1'b0;
    logic        reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cut_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chan_underrun_monitor u_chan_underrun_monitor (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_chan(ev_chan),
        .ev_underrun(ev_underrun), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cut_irq(cut_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ev(input logic [4:0] ch, input logic ur);
        @(negedge clk);
        ev_valid = 1'b1; ev_chan = ch; ev_underrun = ur;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(6'd0, d);     chk("R1 chan0 word", d, 0);
        rd(6'd31, d);    chk("R1 chan31 word", d, 0);
        rd(A_STAT, d);   chk("R1 status", d, 0);
        rd(A_URCNT, d);  chk("R1 underrun counter", d, 0);
        rd(A_CUTCNT, d); chk("R10 cut counter", d, 0);
        chk("R1 irq", cut_irq, 0);
    endtask

    task automatic t_running_total();
        logic [15:0] d;
        wr(6'd1, 16'h01FD);
        ev(5'd1, 1);
        rd(6'd1, d);    chk("R3 increment", d, 16'h01FE);
        ev(5'd1, 0);
        rd(6'd1, d);    chk("R3 good byte keeps tally", d, 16'h01FE);
        ev(5'd1, 1);
        ev(5'd1, 1);
        rd(6'd1, d);    chk("R3 wrap to zero", d, 16'h0100);
        rd(A_URCNT, d); chk("R2 global count", d, 3);
        rd(A_STAT, d);  chk("R2 sticky seen", d, 16'h0001);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, d);  chk("R7 clear seen", d, 0);
    endtask

    task automatic t_report_gate();
        logic [15:0] d;
        wr(6'd2, 16'h0005);
        ev(5'd2, 1);
        rd(6'd2, d);    chk("R2 tally still counts", d, 16'h0006);
        rd(A_URCNT, d); chk("R2 gated global", d, 3);
        rd(A_STAT, d);  chk("R2 gated status", d, 0);
    endtask

    task automatic t_cut_mode();
        logic [15:0] d;
        wr(6'd3, 16'h0210);
        ev(5'd3, 1);
        rd(6'd3, d);     chk("R4 increment", d, 16'h0211);
        ev(5'd3, 0);
        rd(6'd3, d);     chk("R4 good byte clears", d, 16'h0200);
        wr(6'd3, 16'h02FF);
        ev(5'd3, 1);
        rd(6'd3, d);     chk("R6 preload stays", d, 16'h02FF);
        rd(A_CUTCNT, d); chk("R6 no spurious cut", d, 0);
        chk("R6 irq low", cut_irq, 0);
        wr(6'd3, 16'h02FD);
        ev(5'd3, 1);
        chk("R5 no cut at FE", cut_irq, 0);
        ev(5'd3, 1);
        chk("R5 irq", cut_irq, 1);
        rd(A_CUTCNT, d); chk("R5 cut counter", d, 1);
        rd(A_CUTID, d);  chk("R5 cut id", d, 3);
        rd(A_STAT, d);   chk("R5 status bit1", d, 16'h0002);
        ev(5'd3, 1);
        rd(A_CUTCNT, d); chk("R6 no repeat", d, 1);
        rd(6'd3, d);     chk("R4 saturate", d, 16'h02FF);
        ev(5'd3, 0);
        rd(6'd3, d);     chk("R4 recovery", d, 16'h0200);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        wr(A_STAT, 16'h0000);
        chk("R7 write zero ignored", cut_irq, 1);
        wr(6'd7, 16'h02FE);
        ev(5'd7, 1);
        rd(A_CUTCNT, d); chk("R7 second cut counted", d, 2);
        rd(A_CUTID, d);  chk("R7 id replaced", d, 7);
        wr(A_STAT, 16'h0002);
        chk("R7 irq cleared", cut_irq, 0);
        wr(A_CUTCNT, 16'h0000);
        rd(A_CUTCNT, d); chk("R9 cut counter cleared", d, 0);
    endtask

    task automatic t_collision();
        logic [15:0] d;
        @(negedge clk);
        reg_we = 1; reg_addr = 6'd4; reg_wdata = 16'h03FE;
        ev_valid = 1; ev_chan = 5'd4; ev_underrun = 1;
        @(negedge clk);
        reg_we = 0; ev_valid = 0;
        rd(6'd4, d);     chk("R8 update after write", d, 16'h03FF);
        chk("R8 cut from written word", cut_irq, 1);
        rd(A_URCNT, d);  chk("R8 reported", d, 4);
        @(negedge clk);
        reg_we = 1; reg_addr = 6'd5; reg_wdata = 16'h0042;
        ev_valid = 1; ev_chan = 5'd4; ev_underrun = 0;
        @(negedge clk);
        reg_we = 0; ev_valid = 0;
        rd(6'd5, d);     chk("R8 other channel written", d, 16'h0042);
        rd(6'd4, d);     chk("R8 event applied", d, 16'h0300);
        wr(A_STAT, 16'h0003);
    endtask

    task automatic t_saturate();
        logic [15:0] d;
        wr(A_URCNT, 16'h0000);
        wr(6'd6, 16'h0100);
        @(negedge clk);
        ev_valid = 1; ev_chan = 5'd6; ev_underrun = 1;
        repeat (65536) @(negedge clk);
        ev_valid = 0;
        rd(A_URCNT, d);  chk("R9 saturate", d, 16'hFFFF);
        @(negedge clk);
        reg_we = 1; reg_addr = A_URCNT; reg_wdata = 0;
        ev_valid = 1; ev_chan = 5'd6; ev_underrun = 1;
        @(negedge clk);
        reg_we = 0; ev_valid = 0;
        rd(A_URCNT, d);  chk("R9 clear with increment", d, 1);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_running_total();
        t_report_gate();
        t_cut_mode();
        t_irq();
        t_collision();
        t_saturate();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule